// File: doc/BRIEF.md
# Programmable Pixel Combiner Stage

This block is one cascadable general stage of a per-pixel colour combiner. A pixel arrives as a bank of ten named source registers, each holding red, green, blue and alpha as 8-bit signed fixed-point values. In these values, 128 stands for 1.0. The stage picks four RGB operands and four alpha operands from the bank and passes each one through a selectable input mapping. It then forms two products, A·B and C·D. A third result is either their sum or a choice between the two. Each of the three results goes through an output bias and scale and is written back into writable registers of the bank. The updated bank leaves the stage and can feed a further identical stage.

A static configuration word comes with every pixel and is sampled together with it. Pixels flow through a valid/ready stream with one register stage. A pixel is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the consumer takes its contents in the same cycle, so one pixel per clock is sustained. While `out_valid` is high and `out_ready` is low, `out_bank` holds its value and no new pixel is accepted. The producer must keep `in_bank` and `in_cfg` steady while `in_valid` waits for `in_ready`.

Top module: `comb_stage`

## Requirements
- R1: The bank holds register index i in bits [32i+31:32i], with red in the low byte, then green, then blue, and alpha in the top byte. The indices are 0 zero, 1 primary, 2 secondary, 3 constant 0, 4 constant 1, 5 fog, 6 spare 0, 7 spare 1, 8 texture 0 and 9 texture 1. An operand source code of 0, or of 10 and above, reads as all zeros, whatever is on the bus.
- R2: Each operand has a 4-bit source code and a 3-bit map code. The map codes are: 0 passes the value; 1 gives 127−x; 2 gives −x; 3 gives x−64; 4 gives 2·(x−64); 5 to 7 pass the value. Every mapped result saturates to [−128, 127].
- R3: By default each product is computed per channel as floor(a·b/128), saturated.
- R4: Setting an RGB dot flag makes that product floor((aR·bR+aG·bG+aB·bB)/128), saturated, and copies it to all three colour channels.
- R5: With the mux flag clear, the third result is AB+CD. With it set, the third result is CD when bit 7 of the spare 0 alpha byte (input bank) is 1, and AB otherwise.
- R6: The alpha portion works on the alpha bytes of its four operands with the same product, sum and select structure, and has no dot product. Its outputs write only alpha bytes. RGB outputs write only red, green and blue bytes.
- R7: Before write-back, every result is first lowered by 64 when the bias flag is set. It is then scaled by scale code 0 (×1), 1 (×2), 2 (×4) or 3 (÷2, arithmetic shift right).
- R8: Results saturate to [−128, 127] only after bias and scale. The unsaturated sum of two products is kept into that step.
- R9: Destination codes 1 to 9 write the named register. Codes 0 and 10 to 15 discard the result. When destinations collide, the sum/select result beats CD, and CD beats AB. Registers that are not targeted pass through unchanged.
- R10: The zero register slot of `out_bank` is always zero and can never be written.
- R11: After reset `out_valid` is 0 and `in_ready` is 1. A pixel accepted at an edge appears on `out_bank` with `out_valid` after that edge. Back-to-back pixels are taken one per clock. A stalled output holds steady and blocks input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Stage can take a pixel this cycle |
| in_bank | input | 320 | Source register bank of the incoming pixel |
| in_cfg | input | 90 | Stage configuration: 8 operand selectors (7 bits each, RGB A–D then alpha A–D), RGB control (18 bits), alpha control (16 bits) |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_bank | output | 320 | Updated register bank |

## Verification
Some behaviours are checked on every cycle by the assertions. These are the stream rules: a stalled output holds steady, a stall blocks the input, and an accepted pixel always yields a valid output. The assertions also check that the zero slot stays zero, and that a register no destination targets comes out equal to what went in. The arithmetic can only be shown by the bench's directed scenarios, which compare against hand-derived values. That covers the mapping codes with their saturation, per-channel and dot products, sum against select under both states of the spare 0 alpha bit, the bias and scale codes, the alpha datapath and destination collisions.

// File: rtl/comb_pkg.sv
package comb_pkg;
  parameter int CH_W = 8;
  parameter int NREG = 10;
  localparam int PIX_W  = 4 * CH_W;
  localparam int BANK_W = NREG * PIX_W;
  localparam int SEL_W  = 4;
  localparam int WIDE_W = 2 * CH_W + 4;
  localparam int NOPS   = 8;
  localparam int FRAC   = CH_W - 1;
  localparam int CH_MAX = (1 << (CH_W - 1)) - 1;
  localparam int CH_MIN = -(1 << (CH_W - 1));
  localparam int HALF   = 1 << (CH_W - 2);
  localparam int SPARE0 = 6;

  localparam logic [2:0] MAP_INV  = 3'd1;
  localparam logic [2:0] MAP_NEG  = 3'd2;
  localparam logic [2:0] MAP_HALF = 3'd3;
  localparam logic [2:0] MAP_EXP  = 3'd4;

  localparam logic [1:0] SC_X2   = 2'd1;
  localparam logic [1:0] SC_X4   = 2'd2;
  localparam logic [1:0] SC_HALF = 2'd3;

  typedef logic signed [CH_W-1:0]   chan_t;
  typedef logic signed [WIDE_W-1:0] wide_t;
  typedef chan_t [3:0]              pix_t;

  typedef struct packed {
    logic [2:0]       map;
    logic [SEL_W-1:0] src;
  } opsel_t;

  typedef struct packed {
    logic [SEL_W-1:0] dst_sum;
    logic [SEL_W-1:0] dst_cd;
    logic [SEL_W-1:0] dst_ab;
    logic [1:0]       scale;
    logic             bias;
    logic             use_mux;
    logic             dot_cd;
    logic             dot_ab;
  } rgb_ctl_t;

  typedef struct packed {
    logic [SEL_W-1:0] dst_sum;
    logic [SEL_W-1:0] dst_cd;
    logic [SEL_W-1:0] dst_ab;
    logic [1:0]       scale;
    logic             bias;
    logic             use_mux;
  } alpha_ctl_t;

  typedef struct packed {
    alpha_ctl_t            a_ctl;
    rgb_ctl_t              c_ctl;
    opsel_t [NOPS-1:0]     ops;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic chan_t sat(input wide_t v);
    if (v > wide_t'(CH_MAX))      return chan_t'(CH_MAX);
    else if (v < wide_t'(CH_MIN)) return chan_t'(CH_MIN);
    else                          return chan_t'(v);
  endfunction

  function automatic wide_t widen(input chan_t x);
    return wide_t'(x);
  endfunction

  function automatic chan_t map_in(input chan_t x, input logic [2:0] m);
    wide_t w;
    w = widen(x);
    case (m)
      MAP_INV:  return sat(wide_t'(CH_MAX) - w);
      MAP_NEG:  return sat(-w);
      MAP_HALF: return sat(w - wide_t'(HALF));
      MAP_EXP:  return sat((w - wide_t'(HALF)) <<< 1);
      default:  return x;
    endcase
  endfunction

  function automatic wide_t mul_raw(input chan_t a, input chan_t b);
    return widen(a) * widen(b);
  endfunction

  function automatic chan_t mul(input chan_t a, input chan_t b);
    return sat(mul_raw(a, b) >>> FRAC);
  endfunction

  function automatic chan_t scale_bias(input wide_t v, input logic bias,
                                       input logic [1:0] sc);
    wide_t t;
    t = bias ? (v - wide_t'(HALF)) : v;
    case (sc)
      SC_X2:   return sat(t <<< 1);
      SC_X4:   return sat(t <<< 2);
      SC_HALF: return sat(t >>> 1);
      default: return sat(t);
    endcase
  endfunction
endpackage

// File: rtl/comb_operand.sv
module comb_operand
  import comb_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  opsel_t            sel,
  output pix_t              px
);
  pix_t raw;

  // Source 0 and codes past the bank read as zero.
  always_comb begin
    raw = '0;
    for (int i = 1; i < NREG; i++) begin
      if (sel.src == SEL_W'(i)) raw = bank[i*PIX_W +: PIX_W];
    end
  end

  generate
    for (genvar k = 0; k < 4; k++) begin : g_ch
      assign px[k] = map_in(raw[k], sel.map);
    end
  endgenerate
endmodule

// File: rtl/comb_portion.sv
module comb_portion
  import comb_pkg::*;
#(
  parameter int NCH = 3
)(
  input  chan_t [NCH-1:0] a,
  input  chan_t [NCH-1:0] b,
  input  chan_t [NCH-1:0] c,
  input  chan_t [NCH-1:0] d,
  input  logic            dot_ab,
  input  logic            dot_cd,
  input  logic            use_mux,
  input  logic            pick_cd,
  input  logic            bias,
  input  logic [1:0]      scale,
  output chan_t [NCH-1:0] o_ab,
  output chan_t [NCH-1:0] o_cd,
  output chan_t [NCH-1:0] o_third
);
  wide_t acc_ab, acc_cd;
  chan_t dot_ab_v, dot_cd_v;
  chan_t [NCH-1:0] ab_p, cd_p;

  always_comb begin
    acc_ab = '0;
    acc_cd = '0;
    for (int k = 0; k < NCH; k++) begin
      acc_ab = acc_ab + mul_raw(a[k], b[k]);
      acc_cd = acc_cd + mul_raw(c[k], d[k]);
    end
    dot_ab_v = sat(acc_ab >>> FRAC);
    dot_cd_v = sat(acc_cd >>> FRAC);
  end

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      chan_t pk;
      wide_t sum_w;
      assign ab_p[k]    = dot_ab ? dot_ab_v : mul(a[k], b[k]);
      assign cd_p[k]    = dot_cd ? dot_cd_v : mul(c[k], d[k]);
      assign pk         = pick_cd ? cd_p[k] : ab_p[k];
      assign sum_w      = widen(ab_p[k]) + widen(cd_p[k]);
      assign o_ab[k]    = scale_bias(widen(ab_p[k]), bias, scale);
      assign o_cd[k]    = scale_bias(widen(cd_p[k]), bias, scale);
      assign o_third[k] = scale_bias(use_mux ? widen(pk) : sum_w, bias, scale);
    end
  endgenerate
endmodule

// File: rtl/comb_writeback.sv
module comb_writeback
  import comb_pkg::*;
(
  input  logic [BANK_W-1:0] bank_in,
  input  chan_t [2:0]       rgb_ab,
  input  chan_t [2:0]       rgb_cd,
  input  chan_t [2:0]       rgb_third,
  input  chan_t             al_ab,
  input  chan_t             al_cd,
  input  chan_t             al_third,
  input  logic [SEL_W-1:0]  rgb_dst_ab,
  input  logic [SEL_W-1:0]  rgb_dst_cd,
  input  logic [SEL_W-1:0]  rgb_dst_sum,
  input  logic [SEL_W-1:0]  al_dst_ab,
  input  logic [SEL_W-1:0]  al_dst_cd,
  input  logic [SEL_W-1:0]  al_dst_sum,
  output logic [BANK_W-1:0] bank_out
);
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_slot
      if (i == 0) begin : g_zero
        assign bank_out[i*PIX_W +: PIX_W] = '0;
      end else begin : g_live
        pix_t px;
        // Later assignments win: AB, then CD, then the third result.
        always_comb begin
          px = bank_in[i*PIX_W +: PIX_W];
          if (rgb_dst_ab  == SEL_W'(i)) px[2:0] = rgb_ab;
          if (rgb_dst_cd  == SEL_W'(i)) px[2:0] = rgb_cd;
          if (rgb_dst_sum == SEL_W'(i)) px[2:0] = rgb_third;
          if (al_dst_ab   == SEL_W'(i)) px[3]   = al_ab;
          if (al_dst_cd   == SEL_W'(i)) px[3]   = al_cd;
          if (al_dst_sum  == SEL_W'(i)) px[3]   = al_third;
        end
        assign bank_out[i*PIX_W +: PIX_W] = px;
      end
    end
  endgenerate
endmodule

// File: rtl/comb_stage.sv
module comb_stage
  import comb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [CFG_W-1:0]  in_cfg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BANK_W-1:0] out_bank
);
  cfg_t  cfg;
  pix_t  opv [NOPS];
  logic  pick_cd;
  chan_t [2:0] rgb_ab, rgb_cd, rgb_third;
  chan_t [0:0] al_ab, al_cd, al_third;
  logic [BANK_W-1:0] wb_bank;
  logic [BANK_W-1:0] q_bank;
  logic              q_valid;

  assign cfg     = cfg_t'(in_cfg);
  assign pick_cd = in_bank[SPARE0*PIX_W + PIX_W - 1];

  generate
    for (genvar n = 0; n < NOPS; n++) begin : g_op
      comb_operand u_op (
        .bank (in_bank),
        .sel  (cfg.ops[n]),
        .px   (opv[n])
      );
    end
  endgenerate

  comb_portion #(.NCH(3)) u_rgb (
    .a       (opv[0][2:0]),
    .b       (opv[1][2:0]),
    .c       (opv[2][2:0]),
    .d       (opv[3][2:0]),
    .dot_ab  (cfg.c_ctl.dot_ab),
    .dot_cd  (cfg.c_ctl.dot_cd),
    .use_mux (cfg.c_ctl.use_mux),
    .pick_cd (pick_cd),
    .bias    (cfg.c_ctl.bias),
    .scale   (cfg.c_ctl.scale),
    .o_ab    (rgb_ab),
    .o_cd    (rgb_cd),
    .o_third (rgb_third)
  );

  comb_portion #(.NCH(1)) u_alpha (
    .a       (opv[4][3]),
    .b       (opv[5][3]),
    .c       (opv[6][3]),
    .d       (opv[7][3]),
    .dot_ab  (1'b0),
    .dot_cd  (1'b0),
    .use_mux (cfg.a_ctl.use_mux),
    .pick_cd (pick_cd),
    .bias    (cfg.a_ctl.bias),
    .scale   (cfg.a_ctl.scale),
    .o_ab    (al_ab),
    .o_cd    (al_cd),
    .o_third (al_third)
  );

  comb_writeback u_wb (
    .bank_in     (in_bank),
    .rgb_ab      (rgb_ab),
    .rgb_cd      (rgb_cd),
    .rgb_third   (rgb_third),
    .al_ab       (al_ab[0]),
    .al_cd       (al_cd[0]),
    .al_third    (al_third[0]),
    .rgb_dst_ab  (cfg.c_ctl.dst_ab),
    .rgb_dst_cd  (cfg.c_ctl.dst_cd),
    .rgb_dst_sum (cfg.c_ctl.dst_sum),
    .al_dst_ab   (cfg.a_ctl.dst_ab),
    .al_dst_cd   (cfg.a_ctl.dst_cd),
    .al_dst_sum  (cfg.a_ctl.dst_sum),
    .bank_out    (wb_bank)
  );

  assign in_ready = !q_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_bank  <= '0;
    end else begin
      if (in_ready) q_valid <= in_valid;
      if (in_valid && in_ready) q_bank <= wb_bank;
    end
  end

  assign out_valid = q_valid;
  assign out_bank  = q_bank;
endmodule

// File: rtl/comb_stage_chk.sv
module comb_stage_chk
  import comb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BANK_W-1:0] in_bank,
  input logic [CFG_W-1:0]  in_cfg,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BANK_W-1:0] out_bank
);
  localparam int CONST0 = 3;
  cfg_t c;
  logic hit_c0;
  assign c = cfg_t'(in_cfg);
  assign hit_c0 = (c.c_ctl.dst_ab  == SEL_W'(CONST0)) || (c.c_ctl.dst_cd  == SEL_W'(CONST0)) ||
                  (c.c_ctl.dst_sum == SEL_W'(CONST0)) || (c.a_ctl.dst_ab  == SEL_W'(CONST0)) ||
                  (c.a_ctl.dst_cd  == SEL_W'(CONST0)) || (c.a_ctl.dst_sum == SEL_W'(CONST0));

  p_zero_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bank[PIX_W-1:0] == '0));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bank)));

  p_stall_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_passthrough_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !hit_c0) |=>
      (out_bank[CONST0*PIX_W +: PIX_W] == $past(in_bank[CONST0*PIX_W +: PIX_W])));
endmodule

bind comb_stage comb_stage_chk u_chk (.*);

// File: tb/comb_stage_tb.sv
`timescale 1ns/1ps
module comb_stage_tb_top;
  import comb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [BANK_W-1:0] in_bank = '0;
  logic [CFG_W-1:0]  in_cfg = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [BANK_W-1:0] out_bank;

  logic [BANK_W-1:0] bk;
  logic [BANK_W-1:0] ob;
  cfg_t cf;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  comb_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bank(in_bank), .in_cfg(in_cfg), .out_valid(out_valid),
    .out_ready(out_ready), .out_bank(out_bank)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bsat(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int bmul(input int a, input int b);
    return bsat((a * b) >>> 7);
  endfunction

  function automatic int bmap(input int x, input int m);
    case (m)
      1: return bsat(127 - x);
      2: return bsat(-x);
      3: return bsat(x - 64);
      4: return bsat(2 * (x - 64));
      default: return x;
    endcase
  endfunction

  function automatic int gch(input int r, input int ch);
    logic signed [CH_W-1:0] v;
    v = ob[r*PIX_W + ch*CH_W +: CH_W];
    return int'(v);
  endfunction

  task automatic put(input int r, input int cr, input int cg, input int cb, input int ca);
    bk[r*PIX_W + 0*CH_W +: CH_W] = CH_W'(cr);
    bk[r*PIX_W + 1*CH_W +: CH_W] = CH_W'(cg);
    bk[r*PIX_W + 2*CH_W +: CH_W] = CH_W'(cb);
    bk[r*PIX_W + 3*CH_W +: CH_W] = CH_W'(ca);
  endtask

  task automatic base();
    bk = '0;
    cf = '0;
    for (int i = 1; i < NREG; i++) put(i, i*4, i*4+1, i*4+2, i*4+3);
  endtask

  // Products of 32 on AB (tex0*primary) and 16 on CD (tex1*const1).
  task automatic setup_abcd();
    put(8, 64, 64, 64, 0); put(1, 64, 64, 64, 0);
    put(9, 32, 32, 32, 0); put(4, 64, 64, 64, 0);
    cf.ops[0].src = 4'd8; cf.ops[1].src = 4'd1;
    cf.ops[2].src = 4'd9; cf.ops[3].src = 4'd4;
  endtask

  task automatic send();
    @(negedge clk);
    in_valid = 1'b1; in_bank = bk; in_cfg = cf; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ob = out_bank;
    chk("R11 out_valid after accept", int'(out_valid), 1);
  endtask

  task automatic t_reset();
    chk("R11 reset out_valid", int'(out_valid), 0);
    chk("R11 reset in_ready", int'(in_ready), 1);
  endtask

  task automatic t_product();
    base();
    put(8, 64, 32, -64, 5); put(1, 64, 64, 64, 9); put(7, 1, 2, 3, 85);
    cf.ops[0].src = 4'd8; cf.ops[1].src = 4'd1; cf.c_ctl.dst_ab = 4'd7;
    send();
    chk("R3 product red", gch(7, 0), 32);
    chk("R3 product green", gch(7, 1), 16);
    chk("R3 product blue", gch(7, 2), -32);
    chk("R1 R6 alpha byte kept", gch(7, 3), 85);
    chk("R9 untouched fog red", gch(5, 0), 20);
    chk("R9 untouched fog alpha", gch(5, 3), 23);
  endtask

  task automatic t_maps();
    int xs[3] = '{100, -128, 20};
    for (int m = 0; m < 6; m++) begin
      base();
      put(8, xs[0], xs[1], xs[2], 0);
      cf.ops[0].src = 4'd8; cf.ops[0].map = 3'(m);
      cf.ops[1].src = 4'd0; cf.ops[1].map = 3'd1;
      cf.c_ctl.dst_ab = 4'd7;
      send();
      for (int ch = 0; ch < 3; ch++)
        chk($sformatf("R2 R8 map %0d ch %0d", m, ch), gch(7, ch), bmul(bmap(xs[ch], m), 127));
    end
  endtask

  task automatic t_dot();
    base();
    put(8, 64, 64, 64, 0); put(9, 64, 64, 64, 0);
    put(3, -128, -128, -128, 0); put(4, -128, -128, -128, 0);
    cf.ops[0].src = 4'd8; cf.ops[1].src = 4'd9;
    cf.ops[2].src = 4'd3; cf.ops[3].src = 4'd4;
    cf.c_ctl.dot_ab = 1'b1; cf.c_ctl.dot_cd = 1'b1;
    cf.c_ctl.dst_ab = 4'd7; cf.c_ctl.dst_cd = 4'd2;
    send();
    for (int ch = 0; ch < 3; ch++) begin
      chk("R4 dot broadcast", gch(7, ch), 96);
      chk("R4 R8 dot saturates", gch(2, ch), 127);
    end
  endtask

  task automatic t_summux();
    int spare_a[3] = '{0, -128, 64};
    int expv[3] = '{48, 16, 32};
    for (int v = 0; v < 3; v++) begin
      base(); setup_abcd();
      put(6, 0, 0, 0, spare_a[v]);
      cf.c_ctl.use_mux = (v != 0);
      cf.c_ctl.dst_ab = 4'd5; cf.c_ctl.dst_cd = 4'd2; cf.c_ctl.dst_sum = 4'd7;
      send();
      chk($sformatf("R5 third result variant %0d", v), gch(7, 1), expv[v]);
      chk("R5 AB output", gch(5, 0), 32);
      chk("R5 CD output", gch(2, 2), 16);
    end
  endtask

  task automatic t_scale();
    int bs[7] = '{0, 0, 0, 0, 1, 1, 1};
    int sc[7] = '{0, 1, 2, 3, 0, 1, 3};
    int ev[7] = '{32, 64, 127, 16, -32, -64, -16};
    for (int v = 0; v < 7; v++) begin
      base(); setup_abcd();
      cf.ops[2].src = 4'd0;
      cf.c_ctl.bias = bs[v][0]; cf.c_ctl.scale = 2'(sc[v]);
      cf.c_ctl.dst_ab = 4'd7;
      send();
      chk($sformatf("R7 R8 bias %0d scale %0d", bs[v], sc[v]), gch(7, 0), ev[v]);
    end
  endtask

  task automatic t_alpha();
    for (int v = 0; v < 2; v++) begin
      base();
      put(8, 1, 1, 1, 64); put(1, 2, 2, 2, 64);
      put(9, 3, 3, 3, -64); put(3, 4, 4, 4, 64);
      if (v == 1) put(6, 0, 0, 0, -128);
      cf.ops[4].src = 4'd8; cf.ops[5].src = 4'd1;
      cf.ops[6].src = 4'd9; cf.ops[7].src = 4'd3;
      cf.a_ctl.use_mux = (v == 1);
      cf.a_ctl.dst_ab = 4'd7; cf.a_ctl.dst_cd = 4'd2; cf.a_ctl.dst_sum = 4'd5;
      send();
      chk("R6 alpha AB", gch(7, 3), 32);
      chk("R6 alpha CD", gch(2, 3), -32);
      chk("R6 R5 alpha third", gch(5, 3), (v == 1) ? -32 : 0);
      chk("R6 fog rgb untouched", gch(5, 1), 21);
      chk("R6 spare1 rgb untouched", gch(7, 2), 30);
    end
  endtask

  task automatic t_wb();
    base(); setup_abcd();
    cf.c_ctl.dst_ab = 4'd7; cf.c_ctl.dst_cd = 4'd7; cf.c_ctl.dst_sum = 4'd7;
    send();
    chk("R9 sum wins collision", gch(7, 0), 48);
    base(); setup_abcd();
    cf.c_ctl.dst_ab = 4'd7; cf.c_ctl.dst_cd = 4'd7;
    send();
    chk("R9 CD beats AB", gch(7, 0), 16);
    base(); setup_abcd();
    cf.c_ctl.dst_ab = 4'd12; cf.c_ctl.dst_cd = 4'd15; cf.c_ctl.dst_sum = 4'd10;
    cf.a_ctl.dst_ab = 4'd11;
    send();
    chk("R9 out-of-range dst discards", int'(ob == bk), 1);
  endtask

  task automatic t_zero();
    base();
    put(0, 11, 22, 33, 44); put(8, 64, 64, 64, 64);
    cf.ops[0].src = 4'd0; cf.ops[1].src = 4'd0; cf.ops[1].map = 3'd1;
    cf.ops[2].src = 4'd11; cf.ops[2].map = 3'd1; cf.ops[3].src = 4'd8;
    cf.ops[4].src = 4'd8; cf.ops[5].src = 4'd8;
    cf.c_ctl.dst_ab = 4'd0; cf.c_ctl.dst_sum = 4'd7; cf.a_ctl.dst_ab = 4'd0;
    send();
    for (int ch = 0; ch < 4; ch++) chk("R10 zero slot", gch(0, ch), 0);
    chk("R1 zero and out-of-range sources read zero", gch(7, 0), 63);
  endtask

  task automatic t_stream();
    base(); put(7, 1, 0, 0, 0);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_bank = bk; in_cfg = cf;
    @(posedge clk);
    @(negedge clk);
    chk("R11 stalled out_valid", int'(out_valid), 1);
    chk("R11 stall blocks input", int'(in_ready), 0);
    base(); put(7, 2, 0, 0, 0); in_bank = bk;
    @(posedge clk);
    @(negedge clk);
    ob = out_bank;
    chk("R11 held during stall", gch(7, 0), 1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ob = out_bank;
    chk("R11 second pixel after release", gch(7, 0), 2);
    @(posedge clk);
    @(negedge clk);
    chk("R11 drains when idle", int'(out_valid), 0);
    base(); put(7, 1, 0, 0, 0);
    in_valid = 1'b1; in_bank = bk; in_cfg = cf;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      ob = out_bank;
      chk($sformatf("R11 back-to-back pixel %0d", k), gch(7, 0), k);
      chk("R11 ready while streaming", int'(in_ready), 1);
      if (k < 4) begin
        base(); put(7, k + 1, 0, 0, 0); in_bank = bk;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_product();
    t_maps();
    t_dot();
    t_summux();
    t_scale();
    t_alpha();
    t_wb();
    t_zero();
    t_stream();
    done = 1'b1;
    report();
    $finish;
  end
endmodule